// File: doc/BRIEF.md
# Switchable Program-RAM Instruction Cache

This block is the instruction-fetch front end of a processor core. It stands between the core's fetch port, one on-chip program RAM array, and a slow external program memory. A single mode input decides what the array is. With the mode input low, the array is plain program RAM mapped at a fixed, aligned address window. A separate user port can read and write it, and fetches into that window complete without waiting. With the mode input high, the same array becomes the storage of a direct-mapped instruction cache. It is then hidden from the user port, and its window is treated like any other external address.

In cache mode every fetch address is looked up before the external memory is touched. A hit answers in the request cycle and never drives the external port. A miss starts an external read that lasts a parameterized number of wait states. The returned word is forwarded to the fetch port and written into the array in the same cycle, together with its tag and valid bit. Each array word keeps one tag and one valid bit. All valid bits are cleared when the mode input rises and when the flush input is pulsed.

Top module: `pram_icache`

## Requirements
- R1: With cacheEn low, a user write or read whose address lies in the RAM window [RAM_BASE, RAM_BASE+WORDS) gets userAck high in the same cycle. A read returns the last word written at that address. A fetch into the window returns the stored word with fetchReady high in the request cycle, and extReq stays low.
- R2: With cacheEn high, user accesses get no userAck and leave the array contents unchanged.
- R3: With cacheEn high, a fetch into the former RAM window is handled as an external address and returns the external word, not the RAM word.
- R4: An external fetch raises extReq from the cycle after the request, with extAddr equal to the fetch address. fetchReady stays low until exactly EXT_WAIT cycles after the request cycle, and at that point fetchData equals extData.
- R5: A cache miss writes the returned word into the array during the transfer itself. A later fetch of the same address returns that word even if the external memory has since changed.
- R6: A cache hit gives fetchReady in the request cycle, and extReq stays low.
- R7: With cacheEn low, external fetches are never cached: every repeat costs the full EXT_WAIT wait states.
- R8: Mapping is direct. Index = address bits [IDX_W-1:0], and tag = the remaining upper bits. A miss to an address with the same index evicts the older word, so that older word misses again.
- R9: A rising edge of cacheEn invalidates every cached word.
- R10: A one-cycle pulse on flush invalidates every cached word.
- R11: After reset, fetchReady, extReq and userAck are low, and no word is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cacheEn | input | 1 | Mode: 0 = program RAM, 1 = instruction cache |
| flush | input | 1 | Invalidate all cached words |
| fetchReq | input | 1 | Fetch request, held until fetchReady |
| fetchAddr | input | ADDR_W | Fetch address |
| fetchReady | output | 1 | Fetch completes this cycle |
| fetchData | output | DATA_W | Fetched instruction word |
| userWr | input | 1 | User write to the RAM window |
| userRd | input | 1 | User read from the RAM window |
| userAddr | input | ADDR_W | User access address |
| userWrData | input | DATA_W | User write data |
| userRdData | output | DATA_W | User read data |
| userAck | output | 1 | User access accepted |
| extReq | output | 1 | External read in progress |
| extAddr | output | ADDR_W | External read address |
| extData | input | DATA_W | External read data, valid at the last wait cycle |

## Verification
The bench builds the block with ADDR_W=12, WORDS=16, RAM_BASE=64 and EXT_WAIT=3. With only sixteen words, two addresses that share an index but differ in tag, such as 0x105 and 0x115, are easy to write, so eviction is reached with a handful of fetches. The window at 0x040 sits apart from the external test addresses, so a fetch into it shows clearly whether it went to RAM or to external memory. Three wait states make the stall window long enough to check that fetchReady stays low in every cycle before the fill completes. The external model folds a changeable key into its data, which separates a true hit from a silent refetch.

// File: rtl/pram_icache_pkg.sv
package pram_icache_pkg;

  // strobes from the control unit to the datapath
  typedef struct packed {
    logic latchAddr;  // capture fetch address for an external access
    logic fillWr;     // write returned word and tag into the array
    logic setValid;   // mark the filled word valid
    logic validClr;   // clear every valid bit
    logic userWr;     // accepted user write into the array
    logic selExt;     // route external data to the fetch port
  } dpStrobes_t;

  // status from the datapath back to the control unit
  typedef struct packed {
    logic hit;        // fetch address tag matches a valid word
    logic fetchInWin; // fetch address inside the RAM window
    logic userInWin;  // user address inside the RAM window
  } dpStatus_t;

endpackage

// File: rtl/pram_icache_dp.sv
module pram_icache_dp
  import pram_icache_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 24,
  parameter int WORDS    = 1024,
  parameter int RAM_BASE = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic [ADDR_W-1:0] fetchAddr,
  input  logic [ADDR_W-1:0] userAddr,
  input  logic [DATA_W-1:0] userWrData,
  input  logic [DATA_W-1:0] extData,
  output dpStatus_t         stat,
  output logic [DATA_W-1:0] fetchData,
  output logic [DATA_W-1:0] userRdData,
  output logic [ADDR_W-1:0] extAddr
);

  localparam int IDX_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [TAG_W-1:0] WIN_TAG = TAG_W'(RAM_BASE / WORDS);

  logic [DATA_W-1:0] dataMem [WORDS];
  logic [TAG_W-1:0]  tagMem  [WORDS];
  logic [WORDS-1:0]  validQ;
  logic [ADDR_W-1:0] latAddrQ;

  logic [IDX_W-1:0] fetchIdx, userIdx, latIdx;
  logic [TAG_W-1:0] fetchTag, userTag, latTag;

  assign fetchIdx = fetchAddr[IDX_W-1:0];
  assign fetchTag = fetchAddr[ADDR_W-1:IDX_W];
  assign userIdx  = userAddr[IDX_W-1:0];
  assign userTag  = userAddr[ADDR_W-1:IDX_W];
  assign latIdx   = latAddrQ[IDX_W-1:0];
  assign latTag   = latAddrQ[ADDR_W-1:IDX_W];

  // lookup and window decode
  assign stat.hit        = validQ[fetchIdx] && (tagMem[fetchIdx] == fetchTag);
  assign stat.fetchInWin = (fetchTag == WIN_TAG);
  assign stat.userInWin  = (userTag == WIN_TAG);

  assign fetchData  = strb.selExt ? extData : dataMem[fetchIdx];
  assign userRdData = dataMem[userIdx];
  assign extAddr    = latAddrQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latAddrQ <= '0;
    end else if (strb.latchAddr) begin
      latAddrQ <= fetchAddr;
    end
  end

  // array write: a fill and a user write never coincide, fill wins
  always_ff @(posedge clk) begin
    if (strb.fillWr) begin
      dataMem[latIdx] <= extData;
      tagMem[latIdx]  <= latTag;
    end else if (strb.userWr) begin
      dataMem[userIdx] <= userWrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.validClr) begin
      validQ <= '0;
    end else if (strb.setValid) begin
      validQ[latIdx] <= 1'b1;
    end
  end

endmodule

// File: rtl/pram_icache_ctrl.sv
module pram_icache_ctrl
  import pram_icache_pkg::*;
#(
  parameter int EXT_WAIT = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cacheEn,
  input  logic       flush,
  input  logic       fetchReq,
  input  logic       userWr,
  input  logic       userRd,
  input  dpStatus_t  stat,
  output dpStrobes_t strb,
  output logic       fetchReady,
  output logic       userAck,
  output logic       extReq
);

  localparam int CNT_W = $clog2(EXT_WAIT + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(EXT_WAIT);

  typedef enum logic {ST_IDLE, ST_EXT} state_t;

  state_t     stateQ, stateD;
  logic [CNT_W-1:0] cntQ, cntD;
  logic       cacheEnQ;
  logic       fillArmedQ, fillArmedD;
  logic       enRise, invalidate, extDone, startExt;

  assign enRise     = cacheEn && !cacheEnQ;
  assign invalidate = enRise || flush;
  assign extDone    = (stateQ == ST_EXT) && (cntQ == LAST);

  // request-cycle decision: internal RAM, hit, or external access
  always_comb begin
    startExt = 1'b0;
    fetchReady = 1'b0;
    if (stateQ == ST_IDLE) begin
      if (fetchReq) begin
        if (cacheEn ? stat.hit : stat.fetchInWin) fetchReady = 1'b1;
        else                                       startExt = 1'b1;
      end
    end else begin
      fetchReady = extDone;
    end
  end

  always_comb begin
    stateD = stateQ;
    cntD   = cntQ;
    fillArmedD = fillArmedQ;
    if (startExt) begin
      stateD     = ST_EXT;
      cntD       = CNT_W'(1);
      fillArmedD = cacheEn;
    end else if (stateQ == ST_EXT) begin
      if (extDone) begin
        stateD     = ST_IDLE;
        fillArmedD = 1'b0;
      end else begin
        cntD = cntQ + CNT_W'(1);
      end
    end
    // anything that invalidates or leaves cache mode cancels a pending fill
    if (invalidate || !cacheEn) fillArmedD = 1'b0;
  end

  always_comb begin
    strb           = '0;
    strb.latchAddr = startExt;
    strb.selExt    = (stateQ == ST_EXT);
    strb.fillWr    = extDone && fillArmedQ && cacheEn && !invalidate;
    strb.setValid  = strb.fillWr;
    strb.validClr  = invalidate;
    strb.userWr    = userWr && !cacheEn && stat.userInWin;
  end

  assign userAck = (userWr || userRd) && !cacheEn && stat.userInWin;
  assign extReq  = (stateQ == ST_EXT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      cntQ       <= '0;
      cacheEnQ   <= 1'b0;
      fillArmedQ <= 1'b0;
    end else begin
      stateQ     <= stateD;
      cntQ       <= cntD;
      cacheEnQ   <= cacheEn;
      fillArmedQ <= fillArmedD;
    end
  end

endmodule

// File: rtl/pram_icache.sv
module pram_icache
  import pram_icache_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 24,
  parameter int WORDS    = 1024,
  parameter int RAM_BASE = 0,
  parameter int EXT_WAIT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cacheEn,
  input  logic              flush,
  input  logic              fetchReq,
  input  logic [ADDR_W-1:0] fetchAddr,
  output logic              fetchReady,
  output logic [DATA_W-1:0] fetchData,
  input  logic              userWr,
  input  logic              userRd,
  input  logic [ADDR_W-1:0] userAddr,
  input  logic [DATA_W-1:0] userWrData,
  output logic [DATA_W-1:0] userRdData,
  output logic              userAck,
  output logic              extReq,
  output logic [ADDR_W-1:0] extAddr,
  input  logic [DATA_W-1:0] extData
);

  dpStrobes_t strb;
  dpStatus_t  stat;

  pram_icache_ctrl #(.EXT_WAIT(EXT_WAIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .cacheEn(cacheEn), .flush(flush),
    .fetchReq(fetchReq), .userWr(userWr), .userRd(userRd),
    .stat(stat), .strb(strb), .fetchReady(fetchReady),
    .userAck(userAck), .extReq(extReq)
  );

  pram_icache_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .RAM_BASE(RAM_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .fetchAddr(fetchAddr),
    .userAddr(userAddr), .userWrData(userWrData), .extData(extData),
    .stat(stat), .fetchData(fetchData), .userRdData(userRdData),
    .extAddr(extAddr)
  );

endmodule

// File: rtl/pram_icache_chk.sv
module pram_icache_chk #(
  parameter int ADDR_W   = 16,
  parameter int WORDS    = 1024,
  parameter int RAM_BASE = 0
) (
  input logic              clk,
  input logic              rstN,
  input logic              cacheEn,
  input logic              fetchReq,
  input logic [ADDR_W-1:0] fetchAddr,
  input logic              fetchReady,
  input logic              userWr,
  input logic              userRd,
  input logic [ADDR_W-1:0] userAddr,
  input logic              userAck,
  input logic              extReq,
  input logic [ADDR_W-1:0] extAddr
);

  localparam int IDX_W = $clog2(WORDS);
  localparam int TAG_W = ADDR_W - IDX_W;
  localparam logic [TAG_W-1:0] WIN = TAG_W'(RAM_BASE / WORDS);

  logic fetchWin, userWin;
  assign fetchWin = (fetchAddr[ADDR_W-1:IDX_W] == WIN);
  assign userWin  = (userAddr[ADDR_W-1:IDX_W] == WIN);

  // R2: no user access is accepted in cache mode
  p_user_blocked_r2: assert property (@(posedge clk) disable iff (!rstN)
    cacheEn && (userWr || userRd) |-> !userAck);

  // R1: window accesses in RAM mode are accepted at once
  p_user_ack_r1: assert property (@(posedge clk) disable iff (!rstN)
    !cacheEn && (userWr || userRd) && userWin |-> userAck);

  // R1: an idle fetch into the window in RAM mode takes no wait state
  p_int_zero_wait_r1: assert property (@(posedge clk) disable iff (!rstN)
    !cacheEn && fetchReq && fetchWin && !extReq |-> fetchReady);

  // R4: an external access only begins after an unanswered request
  p_ext_start_r4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(extReq) |-> $past(fetchReq && !fetchReady));

  // R4: the external address holds for the whole access
  p_ext_addr_stable_r4: assert property (@(posedge clk) disable iff (!rstN)
    extReq && $past(extReq) |-> $stable(extAddr));

  // R4: an access that has not completed continues
  p_ext_holds_r4: assert property (@(posedge clk) disable iff (!rstN)
    extReq && !fetchReady |=> extReq);

endmodule

bind pram_icache pram_icache_chk #(
  .ADDR_W(ADDR_W), .WORDS(WORDS), .RAM_BASE(RAM_BASE)
) u_chk (
  .clk(clk), .rstN(rstN), .cacheEn(cacheEn), .fetchReq(fetchReq),
  .fetchAddr(fetchAddr), .fetchReady(fetchReady), .userWr(userWr),
  .userRd(userRd), .userAddr(userAddr), .userAck(userAck),
  .extReq(extReq), .extAddr(extAddr)
);

// File: tb/test_pram_icache.sv
module test_pram_icache;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 24;
  localparam int WORDS = 16;
  localparam int RAM_BASE = 64;
  localparam int EXT_WAIT = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cacheEn = 1'b0, flush = 1'b0;
  logic fetchReq = 1'b0;
  logic [ADDR_W-1:0] fetchAddr = '0;
  logic fetchReady;
  logic [DATA_W-1:0] fetchData;
  logic userWr = 1'b0, userRd = 1'b0;
  logic [ADDR_W-1:0] userAddr = '0;
  logic [DATA_W-1:0] userWrData = '0;
  logic [DATA_W-1:0] userRdData;
  logic userAck, extReq;
  logic [ADDR_W-1:0] extAddr;
  logic [DATA_W-1:0] extData;
  logic [ADDR_W-1:0] key = 12'h5A3;

  int nChecks = 0;
  int nFails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  // external memory model: contents depend on a changeable key
  assign extData = {extAddr ^ key, extAddr};

  function automatic logic [DATA_W-1:0] extVal(logic [ADDR_W-1:0] a);
    return {a ^ key, a};
  endfunction

  pram_icache #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS),
    .RAM_BASE(RAM_BASE), .EXT_WAIT(EXT_WAIT)
  ) i_pram_icache (
    .clk(clk), .rstN(rstN), .cacheEn(cacheEn), .flush(flush),
    .fetchReq(fetchReq), .fetchAddr(fetchAddr), .fetchReady(fetchReady),
    .fetchData(fetchData), .userWr(userWr), .userRd(userRd),
    .userAddr(userAddr), .userWrData(userWrData), .userRdData(userRdData),
    .userAck(userAck), .extReq(extReq), .extAddr(extAddr), .extData(extData)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // called just after a falling edge; returns data, wait count, ext use
  task automatic doFetch(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d,
                         output int waits, output bit sawExt, output bit badAddr);
    waits = 0; sawExt = 1'b0; badAddr = 1'b0; d = '0;
    fetchReq = 1'b1; fetchAddr = a;
    forever begin
      #4;
      if (extReq) begin
        sawExt = 1'b1;
        if (extAddr != a) badAddr = 1'b1;
      end
      if (fetchReady) begin
        d = fetchData;
        break;
      end
      waits++;
      if (waits > 40) break;
      @(negedge clk);
    end
    @(negedge clk);
    fetchReq = 1'b0;
  endtask

  task automatic userWrite(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] v,
                           output bit ack);
    userWr = 1'b1; userAddr = a; userWrData = v;
    #4 ack = userAck;
    @(negedge clk);
    userWr = 1'b0;
  endtask

  task automatic userRead(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] v,
                          output bit ack);
    userRd = 1'b1; userAddr = a;
    #4; ack = userAck; v = userRdData;
    @(negedge clk);
    userRd = 1'b0;
  endtask

  task automatic t_reset();
    #4;
    check(!fetchReady && !extReq && !userAck, "R11", "outputs idle after reset",
          {fetchReady, extReq, userAck}, 0);
    @(negedge clk);
  endtask

  task automatic t_ram_mode();
    logic [DATA_W-1:0] d; int w; bit e, b, ack;
    userWrite(12'h043, 24'hABC123, ack);
    check(ack, "R1", "write ack", ack, 1);
    userWrite(12'h047, 24'h777001, ack);
    userWrite(12'h04F, 24'h0F0F0F, ack);
    userRead(12'h043, d, ack);
    check(ack && d == 24'hABC123, "R1", "user readback", d, 24'hABC123);
    userWrite(12'h143, 24'h111111, ack);
    check(!ack, "R1", "ack outside window", ack, 0);
    doFetch(12'h04F, d, w, e, b);
    check(w == 0 && !e, "R1", "window fetch wait states", w, 0);
    check(d == 24'h0F0F0F, "R1", "window fetch data", d, 24'h0F0F0F);
  endtask

  task automatic t_uncached();
    logic [DATA_W-1:0] d; int w; bit e, b;
    doFetch(12'h105, d, w, e, b);
    check(w == EXT_WAIT && e && !b, "R4", "uncached ext timing", w, EXT_WAIT);
    check(d == extVal(12'h105), "R4", "uncached ext data", d, extVal(12'h105));
    doFetch(12'h105, d, w, e, b);
    check(w == EXT_WAIT, "R7", "repeat fetch not cached", w, EXT_WAIT);
  endtask

  task automatic t_miss_hit();
    logic [DATA_W-1:0] d, first; int w; bit e, b;
    cacheEn = 1'b1;
    @(negedge clk);
    doFetch(12'h105, first, w, e, b);
    check(w == EXT_WAIT && e && !b, "R11", "first cached fetch misses", w, EXT_WAIT);
    check(first == extVal(12'h105), "R4", "miss data", first, extVal(12'h105));
    key = 12'h0C3;
    doFetch(12'h105, d, w, e, b);
    check(w == 0 && !e, "R6", "hit zero wait, no ext", w, 0);
    check(d == first, "R5", "hit returns filled word", d, first);
  endtask

  task automatic t_window_ext();
    logic [DATA_W-1:0] d; int w; bit e, b;
    doFetch(12'h04F, d, w, e, b);
    check(w == EXT_WAIT && e, "R3", "window fetch goes external", w, EXT_WAIT);
    check(d == extVal(12'h04F), "R3", "window fetch ext data", d, extVal(12'h04F));
  endtask

  task automatic t_user_blocked();
    logic [DATA_W-1:0] d; bit ack;
    userWrite(12'h047, 24'hDEAD00, ack);
    check(!ack, "R2", "write ack in cache mode", ack, 0);
    userRead(12'h047, d, ack);
    check(!ack, "R2", "read ack in cache mode", ack, 0);
  endtask

  task automatic t_conflict();
    logic [DATA_W-1:0] d; int w; bit e, b;
    doFetch(12'h115, d, w, e, b);
    check(w == EXT_WAIT, "R8", "same-index new tag misses", w, EXT_WAIT);
    doFetch(12'h115, d, w, e, b);
    check(w == 0, "R8", "new tag now hits", w, 0);
    doFetch(12'h105, d, w, e, b);
    check(w == EXT_WAIT && d == extVal(12'h105), "R8", "evicted word refetched",
          w, EXT_WAIT);
  endtask

  task automatic t_flush();
    logic [DATA_W-1:0] d; int w; bit e, b;
    doFetch(12'h120, d, w, e, b);
    doFetch(12'h120, d, w, e, b);
    check(w == 0, "R10", "hit before flush", w, 0);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    doFetch(12'h120, d, w, e, b);
    check(w == EXT_WAIT, "R10", "miss after flush", w, EXT_WAIT);
  endtask

  task automatic t_rerise();
    logic [DATA_W-1:0] d; int w; bit e, b, ack;
    doFetch(12'h121, d, w, e, b);
    doFetch(12'h121, d, w, e, b);
    check(w == 0, "R9", "hit before mode toggle", w, 0);
    cacheEn = 1'b0;
    @(negedge clk);
    userRead(12'h047, d, ack);
    check(ack && d == 24'h777001, "R2", "blocked write left array intact", d, 24'h777001);
    cacheEn = 1'b1;
    @(negedge clk);
    doFetch(12'h121, d, w, e, b);
    check(w == EXT_WAIT, "R9", "miss after enable rise", w, EXT_WAIT);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_ram_mode();
    t_uncached();
    t_miss_hit();
    t_window_ext();
    t_user_blocked();
    t_conflict();
    t_flush();
    t_rerise();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule